// File: doc/BRIEF.md
# Power Domain Sequencing Controller

This block sits in an always-on domain and manages one switchable domain. It runs the domain through a fixed series of steps. To power down, it first clamps the domain's outputs with isolation. It then sends a save command on the retention line, and after that it opens the header switch. To power up, it runs the same steps in reverse: it closes the switch, lets the supply settle, sends a restore command, and finally drops isolation.

The header switch has two control lines. It conducts only while both lines are 1, and the controller changes them one at a time, one cycle apart. A single retention line carries both commands: its rising edge means save and its falling edge means restore. A request that arrives while a sequence is running is held. It takes effect once the controller reaches a resting state (fully on or fully off). Each step has its own dwell time, set by a parameter from 1 to 15 cycles.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it rises, `seq_state` is 0 (ON), both switch controls are 1, `iso_en` is 0, `ret_ctrl` is 0 and `busy` is 0.
- R2: A power-down passes through `seq_state` 1 (isolate), 2 (save) and 3 (switch open), dwelling T_ISO, T_SAVE and T_SWOFF cycles respectively, then rests at 4 (OFF).
- R3: A power-up passes through `seq_state` 5 (switch close), 6 (settle), 7 (restore) and 8 (isolation release), dwelling T_SWON, T_SETTLE, T_RESTORE and T_ISOREL cycles, then rests at 0 (ON).
- R4: `iso_en` is 1 in states 1 to 7 and 0 in states 0 and 8. It is therefore high before either switch control drops and stays high until both are back at 1.
- R5: `ret_ctrl` is 1 in states 2 to 6. It rises (save) with both switch controls high and falls (restore) only after both are high again.
- R6: On power-down, `sw_ctrl1` is 0 in every cycle of states 3 and 4. `sw_ctrl2` drops one cycle later than `sw_ctrl1`, either in the second cycle of state 3 or, when T_SWOFF is 1, on entry to state 4.
- R7: On power-up, `sw_ctrl2` is 1 from the first cycle of state 5. `sw_ctrl1` rises one cycle later, either in the second cycle of state 5 or, when T_SWON is 1, on entry to state 6.
- R8: `busy` is 1 exactly when `seq_state` is neither 0 nor 4.
- R9: A request sampled while `busy` is 1 is held. It takes effect at the first clock edge after the controller reaches the resting state.
- R10: `req_on` in state 0 and `req_off` in state 4 are ignored. The state stays where it is, and the request is not held for later.
- R11: If both requests are high at once in state 0, a power-down starts. If both are high at once in state 4, a power-up starts.
- R12: A request sampled high at a clock edge while resting moves `seq_state` to the first step of its sequence at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_off | input | 1 | Power-down request, sampled on each rising clock edge |
| req_on | input | 1 | Power-up request, sampled on each rising clock edge |
| sw_ctrl1 | output | 1 | Header switch control, first line |
| sw_ctrl2 | output | 1 | Header switch control, second line |
| iso_en | output | 1 | Output clamp enable, active high |
| ret_ctrl | output | 1 | Retention line: rising edge saves, falling edge restores |
| seq_state | output | 4 | Current step code (0 to 8) |
| busy | output | 1 | High while a sequence is running |

## Verification
Every output is decoded from registered state, so any request sampled at a rising edge shows up in the cycle that follows that edge. The step dwell times come straight from the parameters. The bench keeps a queue of the step cycles it expects, filled from those parameters when a request is accepted, and pops one entry per clock. It compares all outputs at the falling edge, half a period after each update. Held requests and conflicting requests are driven at chosen points in a sequence. The bench then checks that the turnaround happens at the first edge after the resting state is reached.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [3:0] {
    PS_ON       = 4'd0,
    PS_ISO_SET  = 4'd1,
    PS_SAVE     = 4'd2,
    PS_SW_OPEN  = 4'd3,
    PS_OFF      = 4'd4,
    PS_SW_CLOSE = 4'd5,
    PS_SETTLE   = 4'd6,
    PS_RESTORE  = 4'd7,
    PS_ISO_CLR  = 4'd8
  } pseq_e;

  // Successor of a running step; resting states map to themselves.
  function automatic pseq_e seq_next(pseq_e s);
    case (s)
      PS_ISO_SET:  return PS_SAVE;
      PS_SAVE:     return PS_SW_OPEN;
      PS_SW_OPEN:  return PS_OFF;
      PS_SW_CLOSE: return PS_SETTLE;
      PS_SETTLE:   return PS_RESTORE;
      PS_RESTORE:  return PS_ISO_CLR;
      PS_ISO_CLR:  return PS_ON;
      default:     return s;
    endcase
  endfunction

  function automatic logic at_rest(pseq_e s);
    return (s == PS_ON) || (s == PS_OFF);
  endfunction

  // Clamp enable: high from the isolate step through the restore step.
  function automatic logic iso_of(pseq_e s);
    return !((s == PS_ON) || (s == PS_ISO_CLR));
  endfunction

  // Retention line: high from save through settle.
  function automatic logic ret_of(pseq_e s);
    return (s == PS_SAVE) || (s == PS_SW_OPEN) || (s == PS_OFF) ||
           (s == PS_SW_CLOSE) || (s == PS_SETTLE);
  endfunction

  // First switch line: drops first on the way down, rises last on the way up.
  function automatic logic sw1_of(pseq_e s, logic first);
    case (s)
      PS_SW_OPEN, PS_OFF: return 1'b0;
      PS_SW_CLOSE:        return !first;
      default:            return 1'b1;
    endcase
  endfunction

  // Second switch line: drops last on the way down, rises first on the way up.
  function automatic logic sw2_of(pseq_e s, logic first);
    case (s)
      PS_OFF:     return 1'b0;
      PS_SW_OPEN: return first;
      default:    return 1'b1;
    endcase
  endfunction

  // Dwell time limited to the range the step counter can hold.
  function automatic int clamp_len(int v, int maxv);
    if (v < 1) return 1;
    if (v > maxv) return maxv;
    return v;
  endfunction

endpackage

// File: rtl/pwr_seq_req.sv
module pwr_seq_req (
  input  logic clk,
  input  logic rst_n,
  input  logic req_off,
  input  logic req_on,
  input  logic resting,
  output logic want_off,
  output logic want_on
);

  logic pend_off;
  logic pend_on;

  // Requests are remembered only while a sequence runs; a resting state
  // either consumes them this edge or discards them as redundant.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_off <= 1'b0;
      pend_on  <= 1'b0;
    end else if (resting) begin
      pend_off <= 1'b0;
      pend_on  <= 1'b0;
    end else begin
      pend_off <= pend_off | req_off;
      pend_on  <= pend_on | req_on;
    end
  end

  assign want_off = req_off | pend_off;
  assign want_on  = req_on | pend_on;

  // R9
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!resting && req_off) |=> want_off);

endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [STEP_W-1:0] len,
  output logic              first,
  output logic              done
);

  localparam logic [STEP_W-1:0] CNT_MAX = '1;

  logic [STEP_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (restart)
      cnt <= '0;
    else if (cnt != CNT_MAX)
      cnt <= cnt + 1'b1;
  end

  assign first = (cnt == '0);
  assign done  = (cnt == len - 1'b1);

endmodule

// File: rtl/pwr_seq_drv.sv
module pwr_seq_drv
  import pwr_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  pseq_e st,
  input  logic  first,
  output logic  sw_ctrl1,
  output logic  sw_ctrl2,
  output logic  iso_en,
  output logic  ret_ctrl,
  output logic  busy
);

  always_comb begin
    sw_ctrl1 = sw1_of(st, first);
    sw_ctrl2 = sw2_of(st, first);
    iso_en   = iso_of(st);
    ret_ctrl = ret_of(st);
    busy     = !at_rest(st);
  end

  // R4
  iso_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_ctrl1 && sw_ctrl2) |-> iso_en);

  // R4
  iso_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso_en) |-> (sw_ctrl1 && sw_ctrl2 && !ret_ctrl));

  // R5
  ret_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ret_ctrl) |-> (sw_ctrl1 && sw_ctrl2 && iso_en));

  // R5
  ret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ret_ctrl) |-> (sw_ctrl1 && sw_ctrl2 && iso_en));

  // R6
  sw_down_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_ctrl2) |-> (!sw_ctrl1 && !$past(sw_ctrl1)));

  // R7
  sw_up_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_ctrl1) |-> (sw_ctrl2 && $past(sw_ctrl2)));

  // R8
  rest_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sw_ctrl1 == sw_ctrl2));

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int STEP_W    = 4,
  parameter int T_ISO     = 2,
  parameter int T_SAVE    = 3,
  parameter int T_SWOFF   = 2,
  parameter int T_SWON    = 2,
  parameter int T_SETTLE  = 4,
  parameter int T_RESTORE = 2,
  parameter int T_ISOREL  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_off,
  input  logic       req_on,
  output logic       sw_ctrl1,
  output logic       sw_ctrl2,
  output logic       iso_en,
  output logic       ret_ctrl,
  output logic [3:0] seq_state,
  output logic       busy
);

  localparam int LEN_MAX = (1 << STEP_W) - 1;
  localparam logic [STEP_W-1:0] L_ISO     = STEP_W'(clamp_len(T_ISO, LEN_MAX));
  localparam logic [STEP_W-1:0] L_SAVE    = STEP_W'(clamp_len(T_SAVE, LEN_MAX));
  localparam logic [STEP_W-1:0] L_SWOFF   = STEP_W'(clamp_len(T_SWOFF, LEN_MAX));
  localparam logic [STEP_W-1:0] L_SWON    = STEP_W'(clamp_len(T_SWON, LEN_MAX));
  localparam logic [STEP_W-1:0] L_SETTLE  = STEP_W'(clamp_len(T_SETTLE, LEN_MAX));
  localparam logic [STEP_W-1:0] L_RESTORE = STEP_W'(clamp_len(T_RESTORE, LEN_MAX));
  localparam logic [STEP_W-1:0] L_ISOREL  = STEP_W'(clamp_len(T_ISOREL, LEN_MAX));

  function automatic logic [STEP_W-1:0] step_len(pseq_e s);
    case (s)
      PS_ISO_SET:  return L_ISO;
      PS_SAVE:     return L_SAVE;
      PS_SW_OPEN:  return L_SWOFF;
      PS_SW_CLOSE: return L_SWON;
      PS_SETTLE:   return L_SETTLE;
      PS_RESTORE:  return L_RESTORE;
      PS_ISO_CLR:  return L_ISOREL;
      default:     return STEP_W'(1);
    endcase
  endfunction

  pseq_e st;
  pseq_e st_nxt;
  logic  resting;
  logic  want_off;
  logic  want_on;
  logic  step_first;
  logic  step_done;
  logic  step_restart;

  assign resting      = at_rest(st);
  assign step_restart = (st_nxt != st);

  pwr_seq_req u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_off  (req_off),
    .req_on   (req_on),
    .resting  (resting),
    .want_off (want_off),
    .want_on  (want_on)
  );

  pwr_seq_timer #(.STEP_W(STEP_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (step_restart),
    .len     (step_len(st)),
    .first   (step_first),
    .done    (step_done)
  );

  always_comb begin
    st_nxt = st;
    case (st)
      PS_ON:   if (want_off) st_nxt = PS_ISO_SET;
      PS_OFF:  if (want_on)  st_nxt = PS_SW_CLOSE;
      default: if (step_done) st_nxt = seq_next(st);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= PS_ON;
    else        st <= st_nxt;
  end

  pwr_seq_drv u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st),
    .first    (step_first),
    .sw_ctrl1 (sw_ctrl1),
    .sw_ctrl2 (sw_ctrl2),
    .iso_en   (iso_en),
    .ret_ctrl (ret_ctrl),
    .busy     (busy)
  );

  assign seq_state = st;

  // R12
  start_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 4'd0 && req_off) |=> (seq_state == 4'd1));

  // R12
  start_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 4'd4 && req_on) |=> (seq_state == 4'd5));

  // R10
  stay_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 4'd0 && !req_off && !want_off) |=> (seq_state == 4'd0));

  // R2
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_state <= 4'd8);

endmodule

// File: tb/pwr_seq_ctrl_tb.sv
module pwr_seq_ctrl_tb;

  localparam int P_ISO = 2, P_SAVE = 3, P_SWOFF = 1, P_SWON = 3;
  localparam int P_SETTLE = 4, P_RESTORE = 2, P_ISOREL = 2;
  localparam int WD_LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_off = 1'b0;
  logic req_on = 1'b0;
  logic sw_ctrl1, sw_ctrl2, iso_en, ret_ctrl, busy;
  logic [3:0] seq_state;

  always #2 clk = ~clk;

  pwr_seq_ctrl #(
    .STEP_W(4), .T_ISO(P_ISO), .T_SAVE(P_SAVE), .T_SWOFF(P_SWOFF),
    .T_SWON(P_SWON), .T_SETTLE(P_SETTLE), .T_RESTORE(P_RESTORE),
    .T_ISOREL(P_ISOREL)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_off(req_off), .req_on(req_on),
    .sw_ctrl1(sw_ctrl1), .sw_ctrl2(sw_ctrl2), .iso_en(iso_en),
    .ret_ctrl(ret_ctrl), .seq_state(seq_state), .busy(busy)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done_flag = 0;
  string tag = "R1";

  // Reference model: queue of (code*16 + cycle index) for each cycle of a running sequence.
  int q[$];
  int rest_code = 0;
  int cur = 0;
  bit m_pend_off = 0, m_pend_on = 0;

  task automatic push_step(int code, int n);
    for (int i = 0; i < (n < 1 ? 1 : n); i++) q.push_back(code * 16 + i);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      q.delete(); rest_code = 0; cur = 0; m_pend_off = 0; m_pend_on = 0;
    end else if (q.size() == 0) begin
      if (rest_code == 0 && (req_off || m_pend_off)) begin
        push_step(1, P_ISO); push_step(2, P_SAVE); push_step(3, P_SWOFF);
        rest_code = 4;
      end else if (rest_code == 4 && (req_on || m_pend_on)) begin
        push_step(5, P_SWON); push_step(6, P_SETTLE); push_step(7, P_RESTORE);
        push_step(8, P_ISOREL);
        rest_code = 0;
      end
      m_pend_off = 0; m_pend_on = 0;
      cur = (q.size() != 0) ? q[0] : rest_code * 16;
    end else begin
      m_pend_off |= req_off; m_pend_on |= req_on;
      void'(q.pop_front());
      cur = (q.size() != 0) ? q[0] : rest_code * 16;
    end
  end

  function automatic bit e_iso(int c);  return !(c == 0 || c == 8); endfunction
  function automatic bit e_ret(int c);  return (c >= 2 && c <= 6); endfunction
  function automatic bit e_busy(int c); return !(c == 0 || c == 4); endfunction
  function automatic bit e_sw1(int c, int i);
    return !(c == 3 || c == 4 || (c == 5 && i == 0));
  endfunction
  function automatic bit e_sw2(int c, int i);
    return !(c == 4 || (c == 3 && i >= 1));
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!done_flag) begin
      int c, i;
      c = cur / 16; i = cur % 16;
      if (!rst_n) c = 0;
      chk(tag, "seq_state", seq_state, c);
      chk("R4", "iso_en", iso_en, e_iso(c));
      chk("R5", "ret_ctrl", ret_ctrl, e_ret(c));
      chk("R6/R7", "sw_ctrl1", sw_ctrl1, e_sw1(c, i));
      chk("R6/R7", "sw_ctrl2", sw_ctrl2, e_sw2(c, i));
      chk("R8", "busy", busy, e_busy(c));
      if (cyc > WD_LIMIT) begin
        chk("watchdog", "timeout", 1, 0);
        finish_run();
      end
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic pulse(bit off, bit on);
    @(negedge clk);
    req_off = off; req_on = on;
    @(negedge clk);
    req_off = 0; req_on = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    tag = "R1";
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    idle(3);
    tag = "R10";            // req_on while ON is dropped
    pulse(0, 1);
    idle(6);
    tag = "R2";             // power-down, R12 start latency
    pulse(1, 0);
    idle(14);
    tag = "R10";            // req_off while OFF is dropped
    pulse(1, 0);
    idle(6);
    tag = "R3";             // power-up
    pulse(0, 1);
    idle(18);
    tag = "R9";             // up request held during power-down
    pulse(1, 0);
    idle(2);
    pulse(0, 1);
    idle(30);
    tag = "R9";             // down request held during power-up
    pulse(1, 0);
    idle(12);
    pulse(0, 1);
    idle(2);
    pulse(1, 0);
    idle(40);
    tag = "R11";            // conflicting requests: down from ON
    pulse(1, 1);
    idle(14);
    tag = "R11";            // conflicting requests: up from OFF
    pulse(1, 1);
    idle(18);
    tag = "R12";
    pulse(1, 0);
    idle(14);
    pulse(0, 1);
    idle(18);
    finish_run();
  end

endmodule